// File: doc/BRIEF.md
# Serial Port with Self-Generated XON/XOFF

This block is a full-duplex serial port. Each frame carries 8 data bits with no parity and one stop bit. A 16-entry receive queue and a 16-entry transmit queue sit behind the serial lines. The local side pushes bytes into the transmit queue with a one-cycle write strobe. It takes bytes from the receive queue by looking at the head byte and then pulsing an acknowledge, which can come one cycle after the byte was used. Each queue reports three flags: not empty, at least half full, and full.

Bit timing comes from a tick at sixteen times the baud rate. An internal divider produces that tick once every `BAUD_DIV` clocks.

The block handles software flow control by itself. The receive queue's half-full flag is registered, and the registered copy is compared with the live flag. When the flag rises, a pause character (0x13) is queued for sending. When it falls, a resume character (0x11) is queued instead. A pending control character goes out before any queued user data. It starts at the next character boundary and never cuts into a frame already on the line. If the flag changes again before the control character leaves, only the newest request is kept.

The transmitter has four states: `TX_IDLE`, `TX_START`, `TX_DATA` and `TX_STOP`.
- `TX_IDLE` moves to `TX_START` when a control character is pending or the queue holds data.
- `TX_START` moves to `TX_DATA` after 16 ticks.
- `TX_DATA` moves to `TX_STOP` after eight bits of 16 ticks each.
- `TX_STOP` moves back to `TX_IDLE` after 16 ticks.

The receiver also has four states: `RX_IDLE`, `RX_START`, `RX_DATA` and `RX_STOP`.
- `RX_IDLE` moves to `RX_START` on a tick that sees the line low.
- `RX_START` re-checks the line on the 8th following tick. It moves to `RX_DATA` if the line is still low, and otherwise returns to `RX_IDLE`.
- `RX_DATA` samples eight bits 16 ticks apart and then moves to `RX_STOP`.
- `RX_STOP` samples the stop bit after 16 ticks and moves to `RX_IDLE`. The byte is stored if the stop bit is high and the queue has room.

Top module: `uflow_uart`

## Requirements
- R1: After reset, `txd` is high and all six queue flags are low.
- R2: Each byte written with `wr_en` is sent on `txd` in write order. A frame is one low start bit, then 8 data bits least significant first, then one high stop bit. Each bit lasts 16 ticks, which is 16*`BAUD_DIV` clocks.
- R3: The transmit flags report: count ≥ 1 (present), count ≥ 8 (half) and count = 16 (full). A write while the queue is full is dropped.
- R4: Correctly framed bytes received on `rxd` appear on `rd_data` in arrival order. The head byte holds until `rd_ack` pulses, and `rd_ack` advances to the next byte.
- R5: The receive flags report: count ≥ 1 (present), count ≥ 8 (half) and count = 16 (full). Once every byte has been acknowledged, all three are low.
- R6: A byte that completes while the receive queue is full is discarded. The 16 stored bytes stay unchanged and in order.
- R7: A low pulse on `rxd` that is high again 8 ticks after it was detected is rejected, and no byte is stored.
- R8: When the receive half flag rises, the byte 0x13 is sent on `txd`.
- R9: When the receive half flag falls, the byte 0x11 is sent on `txd`.
- R10: A pending control character is sent ahead of user bytes already queued. It starts only at a frame boundary, so every frame on `txd` is complete.
- R11: If the half flag falls and rises again while a frame is being sent, only one control character follows, and it matches the latest state of the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd | input | 1 | Serial receive line, idle high |
| txd | output | 1 | Serial transmit line, idle high |
| wr_data | input | DATA_W | Byte to queue for sending |
| wr_en | input | 1 | Write strobe for the transmit queue |
| rd_data | output | DATA_W | Head byte of the receive queue |
| rd_ack | input | 1 | Consume the head byte of the receive queue |
| tx_present | output | 1 | Transmit queue not empty |
| tx_half | output | 1 | Transmit queue at least half full |
| tx_full | output | 1 | Transmit queue full |
| rx_present | output | 1 | Receive queue not empty |
| rx_half | output | 1 | Receive queue at least half full |
| rx_full | output | 1 | Receive queue full |

## Verification
Each result is due a fixed number of cycles after its cause:
- The queue flags change on the clock edge after the accepted write or acknowledge.
- A received byte is stored about 9.5 bit times after its start edge, plus at most one tick and two synchronizer cycles.
- A control character becomes pending one cycle after the half flag changes, and it starts at the end of any frame in flight.

The bench samples flags on the falling clock edge, at least one cycle after the strobe that caused them. It checks received bytes only after a full frame plus slack. It decodes `txd` at mid-bit points counted from each start edge, and compares whole transmit streams only after all queued frames have had time to finish.

// File: rtl/uflow_pkg.sv
package uflow_pkg;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;
    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_t;
    localparam logic [7:0] XON_CHAR  = 8'h11;
    localparam logic [7:0] XOFF_CHAR = 8'h13;
    localparam logic [3:0] TICK_MID  = 4'd7;
    localparam logic [3:0] TICK_LAST = 4'd15;
endpackage

// File: rtl/uflow_tick.sv
module uflow_tick #(
    parameter int DIV = 27
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == LAST) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/uflow_fifo.sv
module uflow_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         present,
    output logic         half,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);
    localparam logic [AW:0]   HALF_CNT = (AW+1)'(DEPTH / 2);
    localparam logic [AW-1:0] LAST_IX  = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          do_push, do_pop;

    assign do_push = push && (cnt != FULL_CNT);
    assign do_pop  = pop && (cnt != '0);

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == LAST_IX) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == LAST_IX) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign dout    = mem[rp];
    assign present = (cnt != '0);
    assign half    = (cnt >= HALF_CNT);
    assign full    = (cnt == FULL_CNT);
endmodule

// File: rtl/uflow_rx.sv
module uflow_rx
    import uflow_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         rxd_in,
    output logic [W-1:0] byte_out,
    output logic         byte_ok
);
    localparam int BW = (W > 1) ? $clog2(W) : 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(W - 1);

    rx_state_t     state, nxt;
    logic [1:0]    sync;
    logic          rxs;
    logic [3:0]    cnt;
    logic [BW-1:0] bidx;

    assign rxs = sync[1];

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:  if (tick && !rxs) nxt = RX_START;
            RX_START: if (tick && cnt == TICK_MID) nxt = rxs ? RX_IDLE : RX_DATA;
            RX_DATA:  if (tick && cnt == TICK_LAST && bidx == LAST_BIT) nxt = RX_STOP;
            RX_STOP:  if (tick && cnt == TICK_LAST) nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync     <= 2'b11;
            cnt      <= '0;
            bidx     <= '0;
            byte_out <= '0;
            byte_ok  <= 1'b0;
        end else begin
            sync    <= {sync[0], rxd_in};
            byte_ok <= 1'b0;
            unique case (state)
                RX_IDLE: begin
                    cnt  <= '0;
                    bidx <= '0;
                end
                RX_START: if (tick) cnt <= (cnt == TICK_MID) ? '0 : cnt + 1'b1;
                RX_DATA: if (tick) begin
                    cnt <= cnt + 1'b1;
                    if (cnt == TICK_LAST) begin
                        byte_out <= {rxs, byte_out[W-1:1]};
                        bidx     <= bidx + 1'b1;
                    end
                end
                RX_STOP: if (tick) begin
                    cnt <= cnt + 1'b1;
                    if (cnt == TICK_LAST) byte_ok <= rxs;
                end
            endcase
        end
    end
endmodule

// File: rtl/uflow_tx.sv
module uflow_tx
    import uflow_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         q_present,
    input  logic [W-1:0] q_data,
    input  logic         fc_valid,
    input  logic [W-1:0] fc_byte,
    output logic         q_pop,
    output logic         fc_take,
    output logic         txd
);
    localparam int BW = (W > 1) ? $clog2(W) : 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(W - 1);

    tx_state_t     state, nxt;
    logic [3:0]    cnt;
    logic [BW-1:0] bidx;
    logic [W-1:0]  shreg;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE:  if (fc_valid || q_present) nxt = TX_START;
            TX_START: if (tick && cnt == TICK_LAST) nxt = TX_DATA;
            TX_DATA:  if (tick && cnt == TICK_LAST && bidx == LAST_BIT) nxt = TX_STOP;
            TX_STOP:  if (tick && cnt == TICK_LAST) nxt = TX_IDLE;
        endcase
    end

    always_comb begin
        fc_take = 1'b0;
        q_pop   = 1'b0;
        txd     = 1'b1;
        unique case (state)
            TX_IDLE: begin
                fc_take = fc_valid;
                q_pop   = !fc_valid && q_present;
            end
            TX_START: txd = 1'b0;
            TX_DATA:  txd = shreg[0];
            TX_STOP:  txd = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            bidx  <= '0;
            shreg <= '0;
        end else begin
            unique case (state)
                TX_IDLE: begin
                    cnt  <= '0;
                    bidx <= '0;
                    if (fc_valid)       shreg <= fc_byte;
                    else if (q_present) shreg <= q_data;
                end
                TX_DATA: if (tick) begin
                    cnt <= cnt + 1'b1;
                    if (cnt == TICK_LAST) begin
                        shreg <= shreg >> 1;
                        bidx  <= bidx + 1'b1;
                    end
                end
                default: if (tick) cnt <= cnt + 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/uflow_uart.sv
module uflow_uart
    import uflow_pkg::*;
#(
    parameter int BAUD_DIV   = 27,
    parameter int FIFO_DEPTH = 16,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    output logic              txd,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              rd_ack,
    output logic              tx_present,
    output logic              tx_half,
    output logic              tx_full,
    output logic              rx_present,
    output logic              rx_half,
    output logic              rx_full
);
    logic              tick;
    logic [DATA_W-1:0] rx_byte, tq_data, flow_byte;
    logic              rx_ok, tq_pop, fc_take;
    logic              hf_prev, flow_pend;

    uflow_tick #(.DIV(BAUD_DIV)) i_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    uflow_rx #(.W(DATA_W)) i_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd_in(rxd),
        .byte_out(rx_byte), .byte_ok(rx_ok)
    );

    uflow_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) i_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_ok), .din(rx_byte), .pop(rd_ack),
        .dout(rd_data), .present(rx_present), .half(rx_half), .full(rx_full)
    );

    uflow_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) i_txq (
        .clk(clk), .rst_n(rst_n), .push(wr_en), .din(wr_data), .pop(tq_pop),
        .dout(tq_data), .present(tx_present), .half(tx_half), .full(tx_full)
    );

    uflow_tx #(.W(DATA_W)) i_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .q_present(tx_present), .q_data(tq_data),
        .fc_valid(flow_pend), .fc_byte(flow_byte),
        .q_pop(tq_pop), .fc_take(fc_take), .txd(txd)
    );

    // A change of the receive half flag (live vs. registered) replaces any pending request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hf_prev   <= 1'b0;
            flow_pend <= 1'b0;
            flow_byte <= '0;
        end else begin
            hf_prev <= rx_half;
            if (hf_prev != rx_half) begin
                flow_pend <= 1'b1;
                flow_byte <= rx_half ? DATA_W'(XOFF_CHAR) : DATA_W'(XON_CHAR);
            end else if (fc_take) begin
                flow_pend <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/uflow_chk.sv
module uflow_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_half,
    input logic              tx_full,
    input logic              rx_present,
    input logic              rx_half,
    input logic              rx_full,
    input logic              rd_ack,
    input logic [DATA_W-1:0] rd_data,
    input logic              flow_pend,
    input logic [DATA_W-1:0] flow_byte
);
    // R3
    tx_full_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full |-> tx_half);

    // R4
    rx_head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_present && !rd_ack) |=> (rx_present && $stable(rd_data)));

    // R6
    rx_full_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !rd_ack) |=> rx_full);

    // R8
    xoff_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_half) |=> (flow_pend && flow_byte == DATA_W'(8'h13)));

    // R9
    xon_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_half) |=> (flow_pend && flow_byte == DATA_W'(8'h11)));
endmodule

bind uflow_uart uflow_chk #(.DATA_W(DATA_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .tx_half(tx_half), .tx_full(tx_full),
    .rx_present(rx_present), .rx_half(rx_half), .rx_full(rx_full),
    .rd_ack(rd_ack), .rd_data(rd_data),
    .flow_pend(flow_pend), .flow_byte(flow_byte)
);

// File: tb/test_uflow_uart.sv
module test_uflow_uart;
    localparam int BD  = 4;
    localparam int BIT = 16 * BD;
    localparam int FRM = 10 * BIT;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rxd = 1'b1;
    logic [7:0] wr_data = '0;
    logic wr_en = 1'b0;
    logic rd_ack = 1'b0;
    logic txd, tx_present, tx_half, tx_full, rx_present, rx_half, rx_full;
    logic [7:0] rd_data;

    always #2.5 clk = ~clk;

    uflow_uart #(.BAUD_DIV(BD), .FIFO_DEPTH(16), .DATA_W(8)) i_uflow_uart (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .txd(txd),
        .wr_data(wr_data), .wr_en(wr_en), .rd_data(rd_data), .rd_ack(rd_ack),
        .tx_present(tx_present), .tx_half(tx_half), .tx_full(tx_full),
        .rx_present(rx_present), .rx_half(rx_half), .rx_full(rx_full)
    );

    int vec = 0, err = 0;
    logic [7:0] cap [0:255];
    logic [7:0] expq [0:255];
    int cap_n = 0, exp_n = 0;
    logic mon_en = 1'b0;
    logic [7:0] sent [0:31];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] ev);
        vec++;
        if (act !== ev) begin
            err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, ev);
        end
    endtask

    function automatic logic [7:0] user_byte();
        logic [7:0] b = 8'($urandom);
        if (b == 8'h11 || b == 8'h13) b = b ^ 8'h40;
        return b;
    endfunction

    function automatic logic half_of(input int n);
        return n >= 8;
    endfunction

    // transmit-line decoder: mid-bit sampling from each start edge
    initial begin
        forever begin
            @(negedge clk);
            if (mon_en && txd === 1'b0) begin
                logic [7:0] b;
                repeat (8 * BD) @(negedge clk);
                for (int i = 0; i < 8; i++) begin
                    repeat (BIT) @(negedge clk);
                    b[i] = txd;
                end
                repeat (BIT) @(negedge clk);
                if (txd !== 1'b1) begin
                    err++; vec++;
                    $display("FAIL R2 stop bit actual=%0b expected=1", txd);
                end
                cap[cap_n] = b;
                cap_n++;
            end
        end
    end

    task automatic check_stream(input string req);
        chk({req, " length"}, 32'(cap_n), 32'(exp_n));
        for (int i = 0; i < exp_n && i < cap_n; i++)
            chk({req, " byte"}, 32'(cap[i]), 32'(expq[i]));
    endtask

    task automatic push_exp(input logic [7:0] b);
        expq[exp_n] = b;
        exp_n++;
    endtask

    task automatic tx_write(input logic [7:0] b);
        @(negedge clk);
        wr_data = b;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] b);
        rxd = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (BIT) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (BIT) @(negedge clk);
    endtask

    task automatic rx_read(input string req, input logic [7:0] ev);
        @(negedge clk);
        chk({req, " present"}, 32'(rx_present), 32'd1);
        chk({req, " data"}, 32'(rd_data), 32'(ev));
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        err++; vec++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vec, err);
        $finish;
    end

    initial begin
        logic [7:0] u [0:15];
        int base, nx, pos;
        void'($urandom(32'h5eed_1234));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 txd", 32'(txd), 32'd1);
        chk("R1 flags", 32'({tx_present, tx_half, tx_full, rx_present, rx_half, rx_full}), 32'd0);
        mon_en = 1'b1;

        // R2 a few random bytes
        for (int i = 0; i < 5; i++) begin
            logic [7:0] b = user_byte();
            tx_write(b);
            push_exp(b);
        end
        repeat (7 * FRM) @(negedge clk);
        check_stream("R2");

        // R3 back-to-back burst of 17 fills the queue; 18th dropped
        @(negedge clk);
        for (int i = 0; i < 17; i++) begin
            logic [7:0] b = user_byte();
            wr_data = b; wr_en = 1'b1;
            push_exp(b);
            @(negedge clk);
        end
        wr_en = 1'b0;
        chk("R3 full", 32'(tx_full), 32'd1);
        chk("R3 half", 32'(tx_half), 32'd1);
        chk("R3 present", 32'(tx_present), 32'd1);
        tx_write(8'h5a);
        repeat (19 * FRM) @(negedge clk);
        check_stream("R3");
        chk("R3 drained", 32'({tx_present, tx_half, tx_full}), 32'd0);

        // R4 receive a few random bytes
        for (int i = 0; i < 4; i++) begin
            sent[i] = 8'($urandom);
            send_frame(sent[i]);
        end
        repeat (8) @(negedge clk);
        chk("R5 half after 4", 32'(rx_half), 32'(half_of(4)));
        for (int i = 0; i < 4; i++) rx_read("R4", sent[i]);
        chk("R5 empty", 32'({rx_present, rx_half, rx_full}), 32'd0);

        // R7 short low pulse rejected
        rxd = 1'b0;
        repeat (3 * BD) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * FRM) @(negedge clk);
        chk("R7 no byte", 32'(rx_present), 32'd0);
        chk("R7 no tx", 32'(cap_n), 32'(exp_n));

        // R8 crossing half sends XOFF; R6 overflow drop; R9 falling sends XON
        for (int i = 0; i < 7; i++) begin
            sent[i] = 8'($urandom);
            send_frame(sent[i]);
        end
        repeat (8) @(negedge clk);
        chk("R5 half at 7", 32'(rx_half), 32'(half_of(7)));
        sent[7] = 8'($urandom);
        send_frame(sent[7]);
        repeat (8) @(negedge clk);
        chk("R5 half at 8", 32'(rx_half), 32'(half_of(8)));
        push_exp(8'h13);
        repeat (2 * FRM) @(negedge clk);
        check_stream("R8");
        for (int i = 8; i < 17; i++) begin
            sent[i] = 8'($urandom);
            send_frame(sent[i]);
        end
        repeat (8) @(negedge clk);
        chk("R6 full", 32'(rx_full), 32'd1);
        for (int i = 0; i < 16; i++) rx_read("R6", sent[i]);
        chk("R6 extra dropped", 32'(rx_present), 32'd0);
        push_exp(8'h11);
        repeat (2 * FRM) @(negedge clk);
        check_stream("R9");

        // R10 XOFF overtakes queued user bytes, between whole frames
        base = cap_n;
        fork
            begin
                @(negedge clk);
                for (int i = 0; i < 16; i++) begin
                    u[i] = user_byte();
                    wr_data = u[i]; wr_en = 1'b1;
                    @(negedge clk);
                end
                wr_en = 1'b0;
            end
            begin
                for (int i = 0; i < 8; i++) begin
                    sent[i] = 8'($urandom);
                    send_frame(sent[i]);
                end
            end
        join
        repeat (11 * FRM) @(negedge clk);
        chk("R10 length", 32'(cap_n - base), 32'd17);
        nx = 0; pos = -1;
        for (int i = base; i < cap_n; i++) begin
            if (cap[i] == 8'h13) pos = i - base;
            else begin
                if (nx < 16) chk("R10 order", 32'(cap[i]), 32'(u[nx]));
                nx++;
            end
        end
        chk("R10 user count", 32'(nx), 32'd16);
        chk("R10 xoff ahead of queued", 32'(pos > 0 && pos < 16), 32'd1);
        for (int i = base; i < cap_n; i++) push_exp(cap[i]);
        for (int i = 0; i < 8; i++) rx_read("R10 drain", sent[i]);
        push_exp(8'h11);
        repeat (2 * FRM) @(negedge clk);
        check_stream("R10 xon");

        // R11 fall then rise within one frame: only XOFF follows
        for (int i = 0; i < 8; i++) begin
            sent[i] = 8'($urandom);
            send_frame(sent[i]);
        end
        push_exp(8'h13);
        repeat (2 * FRM) @(negedge clk);
        for (int i = 0; i < 3; i++) u[i] = user_byte();
        sent[8] = 8'($urandom);
        fork
            send_frame(sent[8]);
            begin
                repeat (5 * BIT) @(negedge clk);
                for (int i = 0; i < 3; i++) begin
                    wr_data = u[i]; wr_en = 1'b1;
                    @(negedge clk);
                end
                wr_en = 1'b0;
            end
            begin
                repeat (9 * BIT) @(negedge clk);
                rx_read("R11 read", sent[0]);
            end
        join
        push_exp(u[0]);
        push_exp(8'h13);
        push_exp(u[1]);
        push_exp(u[2]);
        repeat (4 * FRM) @(negedge clk);
        check_stream("R11");
        for (int i = 1; i < 9; i++) rx_read("R11 drain", sent[i]);
        push_exp(8'h11);
        repeat (2 * FRM) @(negedge clk);
        check_stream("R11 xon");
        chk("R5 final", 32'({rx_present, rx_half, rx_full, tx_present}), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", vec, err);
        $finish;
    end
endmodule